// File: doc/BRIEF.md
# SPI Pin Control with Mode-Fault Detection

This block owns the six pads of a small general-purpose port, four of which can be shared with an SPI shift engine. When the SPI is off, every pad is plain GPIO: a software direction register picks the output enable and a port data register supplies the level. When the SPI is on, pads 5 to 2 take the roles slave select, serial clock, MOSI and MISO. Each pad's direction then follows the master/slave mode rather than the direction register. Pads 1 and 0 stay GPIO in every mode.

In master mode with direction bit 5 clear, the slave-select pad becomes a fault sensor. It passes through a synchronizer. As soon as a low level appears at the synchronizer output, all four SPI pads are released in that same cycle. On the next edge a sticky fault flag is set and the internal enable and master controls are cleared. Enable writes have no effect while the flag is set, so the pads stay released until software clears the flag and enables the SPI again. A separate open-drain option makes every pad drive only low and release for a high.

Top module: `serport_pinctl`

## Requirements
- R1: The direction register resets to 0 and can be written at any time. `dir_rdata[5:0]` returns the stored bits and `dir_rdata[7:6]` always reads 0.
- R2: While `spi_en` is 0, `pad_oe[i]` equals direction bit i and `pad_out[i]` equals `port_dout[i]` for all six pads (open-drain off).
- R3: In master mode, pad 4 drives `eng_sck_out` and pad 3 drives `eng_mosi_out`, both with output enable 1. Pad 2 has output enable 0.
- R4: In slave mode, pads 5, 4 and 3 have output enable 0 whatever the direction register holds. Pad 2 drives `eng_miso_out` only while the synchronized slave select is low. `eng_ss_n` gives the synchronized slave-select level.
- R5: In master mode with direction bit 5 at 0, a low on pad 5 reaches the fault logic after SYNC_STAGES clock edges. In that same cycle `pad_oe[5:2]` becomes 0. The next edge sets `fault_flag` and clears `spi_en` and `spi_mst`.
- R6: In master mode with direction bit 5 at 1, pad 5 is a GPIO output that carries `port_dout[5]`. A low level on it raises no fault.
- R7: While `fault_flag` is 1, `pad_oe[5:2]` stays 0 and a control write cannot set `spi_en`. A `fault_clr` pulse clears the flag, and a later control write enables the SPI again.
- R8: With `odrain` at 1, every pad that would drive 0 has output enable 1 with `pad_out` 0. Every pad that would drive 1, or that is an input, has output enable 0.
- R9: Pads 1 and 0 act as GPIO in every SPI mode and fault state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_en | input | 1 | SPI enable value to write |
| cfg_mst | input | 1 | Master mode value to write |
| fault_clr | input | 1 | Clears the sticky fault flag |
| dir_we | input | 1 | Direction register write strobe |
| dir_wdata | input | 8 | Direction register write data |
| dir_rdata | output | 8 | Direction register read data |
| port_dout | input | 6 | GPIO output levels |
| odrain | input | 1 | Open-drain option for all pads |
| eng_sck_out | input | 1 | Clock from the shift engine |
| eng_mosi_out | input | 1 | MOSI data from the shift engine |
| eng_miso_out | input | 1 | MISO data from the shift engine |
| eng_sck_in | output | 1 | Clock pad level to the engine |
| eng_mosi_in | output | 1 | MOSI pad level to the engine |
| eng_miso_in | output | 1 | MISO pad level to the engine |
| eng_ss_n | output | 1 | Synchronized slave select (1 outside slave mode) |
| spi_en | output | 1 | Effective SPI enable |
| spi_mst | output | 1 | Effective master mode |
| fault_flag | output | 1 | Sticky mode-fault flag |
| gpio_in | output | 6 | Pad levels for the GPIO read path |
| pad_in | input | 6 | Pad input levels |
| pad_oe | output | 6 | Pad output enables |
| pad_out | output | 6 | Pad output levels |

## Verification
The bench builds the block with the default two-stage synchronizer. This makes the fault delay short and fixed, so release and flag timing can be checked on exact edges. With the SPI off, it sweeps every direction value against every data value with open-drain both on and off. That covers the whole GPIO mapping. In master mode it sweeps all engine output levels. In slave mode it covers every combination of slave-select level and direction bit 5. The fault sequence is run step by step, including blocked re-enables and recovery.

// File: rtl/serport_pkg.sv
package serport_pkg;
  localparam int PORT_W   = 6;
  localparam int PIN_SS   = 5;
  localparam int PIN_SCK  = 4;
  localparam int PIN_MOSI = 3;
  localparam int PIN_MISO = 2;
  localparam int SPI_LO   = 2;
  localparam int RD_W     = 8;

  // pad enable after the open-drain option
  function automatic logic pad_enable(input logic want_oe, input logic level, input logic od);
    return od ? (want_oe & ~level) : want_oe;
  endfunction

  // pad level after the open-drain option
  function automatic logic pad_level(input logic level, input logic od);
    return od ? 1'b0 : level;
  endfunction
endpackage

// File: rtl/serport_sync.sv
module serport_sync #(
  parameter int    STAGES    = 2,
  parameter logic  RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RESET_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/serport_mode_ctl.sv
module serport_mode_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_we,
  input  logic cfg_en,
  input  logic cfg_mst,
  input  logic fault_clr,
  input  logic fault_arm,
  input  logic ss_sync,
  output logic spi_en,
  output logic spi_mst,
  output logic fault_flag,
  output logic fault_now
);
  logic en_q, mst_q, flag_q;

  assign fault_now = en_q & mst_q & fault_arm & ~ss_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mst_q  <= 1'b0;
      flag_q <= 1'b0;
    end else if (fault_now) begin
      en_q   <= 1'b0;
      mst_q  <= 1'b0;
      flag_q <= 1'b1;
    end else begin
      if (fault_clr) flag_q <= 1'b0;
      if (cfg_we) begin
        en_q  <= cfg_en & ~flag_q;
        mst_q <= cfg_mst;
      end
    end
  end

  assign spi_en     = en_q;
  assign spi_mst    = mst_q;
  assign fault_flag = flag_q;

  AST_FAULT_TRIPS: assert property (@(posedge clk) disable iff (!rst_n)
    fault_now |=> (fault_flag && !spi_en && !spi_mst)); // R5
  AST_NO_REENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_flag |=> !spi_en); // R7
endmodule

// File: rtl/serport_pad_mux.sv
module serport_pad_mux
  import serport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_en,
  input  logic              spi_mst,
  input  logic              fault_hold,
  input  logic [PORT_W-1:0] dir,
  input  logic [PORT_W-1:0] dout,
  input  logic              eng_sck,
  input  logic              eng_mosi,
  input  logic              eng_miso,
  input  logic              ss_sync,
  input  logic              odrain,
  output logic [PORT_W-1:0] pad_oe,
  output logic [PORT_W-1:0] pad_out
);
  logic [PORT_W-1:0] want_oe, want_lvl;

  always_comb begin
    want_oe  = dir;
    want_lvl = dout;
    if (fault_hold) begin
      want_oe[PORT_W-1:SPI_LO] = '0;
    end else if (spi_en) begin
      if (spi_mst) begin
        want_oe[PIN_SS]    = dir[PIN_SS];
        want_oe[PIN_SCK]   = 1'b1;
        want_lvl[PIN_SCK]  = eng_sck;
        want_oe[PIN_MOSI]  = 1'b1;
        want_lvl[PIN_MOSI] = eng_mosi;
        want_oe[PIN_MISO]  = 1'b0;
      end else begin
        want_oe[PIN_SS]    = 1'b0;
        want_oe[PIN_SCK]   = 1'b0;
        want_oe[PIN_MOSI]  = 1'b0;
        want_oe[PIN_MISO]  = ~ss_sync;
        want_lvl[PIN_MISO] = eng_miso;
      end
    end
  end

  for (genvar i = 0; i < PORT_W; i++) begin : g_pad
    assign pad_oe[i]  = pad_enable(want_oe[i], want_lvl[i], odrain);
    assign pad_out[i] = pad_level(want_lvl[i], odrain);
  end

  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_hold |-> (pad_oe[PORT_W-1:SPI_LO] == '0)); // R7
  AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && !spi_mst && ss_sync && !fault_hold) |-> !pad_oe[PIN_MISO]); // R4
  AST_OD_SINK: assert property (@(posedge clk) disable iff (!rst_n)
    odrain |-> ((pad_oe & pad_out) == '0)); // R8
  AST_LOW_GPIO: assert property (@(posedge clk) disable iff (!rst_n)
    !odrain |-> (pad_oe[SPI_LO-1:0] == dir[SPI_LO-1:0])); // R9
endmodule

// File: rtl/serport_pinctl.sv
module serport_pinctl
  import serport_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_en,
  input  logic              cfg_mst,
  input  logic              fault_clr,
  input  logic              dir_we,
  input  logic [RD_W-1:0]   dir_wdata,
  output logic [RD_W-1:0]   dir_rdata,
  input  logic [PORT_W-1:0] port_dout,
  input  logic              odrain,
  input  logic              eng_sck_out,
  input  logic              eng_mosi_out,
  input  logic              eng_miso_out,
  output logic              eng_sck_in,
  output logic              eng_mosi_in,
  output logic              eng_miso_in,
  output logic              eng_ss_n,
  output logic              spi_en,
  output logic              spi_mst,
  output logic              fault_flag,
  output logic [PORT_W-1:0] gpio_in,
  input  logic [PORT_W-1:0] pad_in,
  output logic [PORT_W-1:0] pad_oe,
  output logic [PORT_W-1:0] pad_out
);
  localparam int PAD_W = RD_W - PORT_W;

  logic [PORT_W-1:0] dir_q;
  logic              ss_sync;
  logic              fault_now;
  logic              fault_hold;
  logic [PAD_W-1:0]  unused_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (dir_we) dir_q <= dir_wdata[PORT_W-1:0];
  end

  assign unused_hi = dir_wdata[RD_W-1:PORT_W];
  assign dir_rdata = {{PAD_W{1'b0}}, dir_q};

  serport_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) ss_sync_i (
    .clk(clk), .rst_n(rst_n), .d(pad_in[PIN_SS]), .q(ss_sync)
  );

  serport_mode_ctl mode_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_en(cfg_en), .cfg_mst(cfg_mst),
    .fault_clr(fault_clr), .fault_arm(~dir_q[PIN_SS]), .ss_sync(ss_sync),
    .spi_en(spi_en), .spi_mst(spi_mst), .fault_flag(fault_flag), .fault_now(fault_now)
  );

  assign fault_hold = fault_flag | fault_now;

  serport_pad_mux mux_i (
    .clk(clk), .rst_n(rst_n), .spi_en(spi_en), .spi_mst(spi_mst),
    .fault_hold(fault_hold), .dir(dir_q), .dout(port_dout),
    .eng_sck(eng_sck_out), .eng_mosi(eng_mosi_out), .eng_miso(eng_miso_out),
    .ss_sync(ss_sync), .odrain(odrain), .pad_oe(pad_oe), .pad_out(pad_out)
  );

  assign eng_sck_in  = pad_in[PIN_SCK];
  assign eng_mosi_in = pad_in[PIN_MOSI];
  assign eng_miso_in = pad_in[PIN_MISO];
  assign eng_ss_n    = (spi_en && !spi_mst) ? ss_sync : 1'b1;
  assign gpio_in     = pad_in;

  AST_DIR_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_rdata[RD_W-1:PORT_W] == '0) && (unused_hi == unused_hi)); // R1
  AST_GPIO_SS: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && spi_mst && dir_q[PIN_SS]) |=> !fault_flag || $past(fault_flag)); // R6
endmodule

// File: tb/serport_pinctl_tb.sv
module serport_pinctl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_en = 0, cfg_mst = 0, fault_clr = 0, dir_we = 0;
  logic [7:0] dir_wdata = '0, dir_rdata;
  logic [5:0] port_dout = '0, gpio_in, pad_in = 6'h3F, pad_oe, pad_out;
  logic odrain = 0, e_sck = 0, e_mosi = 0, e_miso = 0;
  logic eng_sck_in, eng_mosi_in, eng_miso_in, eng_ss_n, spi_en, spi_mst, fault_flag;
  int n_cmp = 0, n_bad = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serport_pinctl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_en(cfg_en), .cfg_mst(cfg_mst),
    .fault_clr(fault_clr), .dir_we(dir_we), .dir_wdata(dir_wdata), .dir_rdata(dir_rdata),
    .port_dout(port_dout), .odrain(odrain), .eng_sck_out(e_sck), .eng_mosi_out(e_mosi),
    .eng_miso_out(e_miso), .eng_sck_in(eng_sck_in), .eng_mosi_in(eng_mosi_in),
    .eng_miso_in(eng_miso_in), .eng_ss_n(eng_ss_n), .spi_en(spi_en), .spi_mst(spi_mst),
    .fault_flag(fault_flag), .gpio_in(gpio_in), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // expected pads: returns {oe, out}; mode 0 off, 1 master, 2 slave, 3 released
  function automatic logic [11:0] model(input int mode, input logic [5:0] dir,
      input logic [5:0] dv, input logic ss, input logic od);
    logic [5:0] oe = dir, lv = dv, eo, eout;
    if (mode == 1) begin
      oe[4] = 1; lv[4] = e_sck; oe[3] = 1; lv[3] = e_mosi; oe[2] = 0;
    end else if (mode == 2) begin
      oe[5:3] = 3'b000; oe[2] = (ss == 1'b0); lv[2] = e_miso;
    end else if (mode == 3) begin
      oe[5:2] = 4'b0000;
    end
    for (int i = 0; i < 6; i++) begin
      eo[i]   = od ? (oe[i] && (lv[i] == 1'b0)) : oe[i];
      eout[i] = od ? 1'b0 : lv[i];
    end
    return {eo, eout};
  endfunction

  task automatic wr_dir(input logic [7:0] v);
    @(negedge clk); dir_we = 1; dir_wdata = v;
    @(negedge clk); dir_we = 0;
  endtask

  task automatic wr_cfg(input logic en, input logic mst);
    @(negedge clk); cfg_we = 1; cfg_en = en; cfg_mst = mst;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle(2); rst_n = 1; idle(1);
    // R1 reset state
    check("R1 reset dir", dir_rdata, 8'h00);
    check("R2 reset oe", pad_oe, 6'h00);
    wr_dir(8'hFF);
    check("R1 high bits read 0", dir_rdata, 8'h3F);

    // R2, R8 exhaustive GPIO sweep with SPI off
    for (int d = 0; d < 64; d++) begin
      wr_dir(8'(d) | 8'hC0);
      check("R1 readback", dir_rdata, 8'(d));
      for (int v = 0; v < 64; v++) begin
        for (int o = 0; o < 2; o++) begin
          port_dout = 6'(v); odrain = o[0]; #1;
          check(o ? "R8 od gpio" : "R2 gpio", {pad_oe, pad_out},
                model(0, 6'(d), 6'(v), 1'b1, o[0]));
        end
      end
    end
    odrain = 0;

    // R3 master sweep
    wr_dir(8'h03); wr_cfg(1, 1); idle(1);
    check("R3 enabled", {spi_en, spi_mst}, 2'b11);
    for (int e = 0; e < 8; e++) begin
      for (int o = 0; o < 2; o++) begin
        {e_sck, e_mosi, e_miso} = 3'(e); odrain = o[0]; port_dout = 6'(e * 5); #1;
        check(o ? "R8 od master" : "R3 master", {pad_oe, pad_out},
              model(1, 6'h03, 6'(e * 5), 1'b1, o[0]));
      end
    end
    odrain = 0;

    // R6 dir5 set: low on ss is GPIO, no fault
    wr_dir(8'h20); port_dout = 6'h00; pad_in[5] = 0; idle(5);
    check("R6 no fault", {fault_flag, spi_en}, 2'b01);
    check("R6 ss gpio", {pad_oe[5], pad_out[5]}, 2'b10);
    pad_in[5] = 1; idle(3);

    // R4 slave sweep
    wr_cfg(1, 0);
    for (int s = 0; s < 2; s++) begin
      for (int d5 = 0; d5 < 2; d5++) begin
        wr_dir(d5 ? 8'h3F : 8'h1F); pad_in[5] = s[0]; e_miso = ~s[0]; idle(3);
        check("R4 slave pads", {pad_oe, pad_out},
              model(2, d5 ? 6'h3F : 6'h1F, port_dout, s[0], 1'b0));
        check("R4 ss to engine", eng_ss_n, s[0]);
        check("R9 low pads slave", pad_oe[1:0], 2'b11);
      end
    end
    pad_in[5] = 1; idle(3);

    // R5 fault timing
    wr_dir(8'h1F); wr_cfg(1, 1); idle(1);
    check("R5 pre-fault drive", pad_oe[4:3], 2'b11);
    @(negedge clk); pad_in[5] = 0;
    @(posedge clk); #1;
    check("R5 one edge still driving", {pad_oe[4:3], fault_flag}, 3'b110);
    @(posedge clk); #1;
    check("R5 released on sync edge", pad_oe[5:2], 4'h0);
    check("R5 flag not yet", fault_flag, 1'b0);
    @(posedge clk); #1;
    check("R5 flag set", {fault_flag, spi_en, spi_mst}, 3'b100);
    check("R9 low pads in fault", pad_oe[1:0], 2'b11);

    // R7 sticky, re-enable blocked
    pad_in[5] = 1; wr_cfg(1, 1); idle(2);
    check("R7 enable blocked", {fault_flag, spi_en}, 2'b10);
    check("R7 pads held", pad_oe[5:2], 4'h0);
    @(negedge clk); fault_clr = 1; @(negedge clk); fault_clr = 0;
    check("R7 flag cleared", fault_flag, 1'b0);
    check("R2 gpio after clear", pad_oe, 6'h1F);
    wr_cfg(1, 1); idle(1);
    check("R7 re-enabled", {spi_en, spi_mst, pad_oe[4:3]}, 4'hF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule